// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Sequencer

This block is the memory-side sequencer for a synchronous burst read from a flash-style device. A host raises a one-cycle request with a start address. The block then counts a programmable number of active burst-clock edges as initial latency. After that it puts one data word on its output per active edge. While it does so it drives a WAIT pin that tells the host whether the word now on the bus can be used.

The configuration bits are sampled at request time and control five things:
- how the WAIT level encodes "not ready";
- whether WAIT leads the wait period by one burst-clock period;
- whether each word is held for one or two burst-clock periods;
- whether the burst walks addresses in wrapped sequential order or in interleaved (XOR) order;
- which burst-clock transition counts as active.

The exceptions are the WAIT polarity bit and the edge-select bit, which are applied live. The block runs on a faster system clock and oversamples the burst clock. The stored words live in a small internal read-only array. Dropping chip enable aborts a burst at once.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset and whenever no burst is active, WAIT sits at its inactive level and `dout` is zero.
- R2: The word stored at address `a` is `{~a8, a8}`, where `a8` is `a` zero-extended to 8 bits. That value appears on `dout` in every period where the word is valid.
- R3: `dout` is zero in every period in which the output is not valid. With `cfg_wait_early`=0, WAIT is asserted in exactly those periods.
- R4: With `cfg_wait_pol`=0, WAIT is asserted low (inactive high). With `cfg_wait_pol`=1, it is asserted high (inactive low).
- R5: With `cfg_rise`=1 the rising burst-clock transition is active, and with 0 the falling one is. The other transition changes neither output.
- R6: The first word appears at the Nth active edge after the request, where N is `cfg_lat` (2 to 7). Values 0 and 1 act as 2. All periods before the first word are wait periods.
- R7: `cfg_len8`=0 gives a 4-word burst and 1 gives an 8-word burst. One period after the last word ends, the block is idle again.
- R8: With `cfg_seq`=1 the addresses are sequential and wrap inside the aligned group of the burst length. Word i is read from `(start & ~(L-1)) | ((start+i) & (L-1))`.
- R9: With `cfg_seq`=0 the order is interleaved: word i is read from `start ^ i`.
- R10: With `cfg_hold2`=1, each word stays valid for two active-edge periods. One wait period separates consecutive words, and none follows the last word.
- R11: With `cfg_wait_early`=1, WAIT in each period shows the wait status of the following period. It is asserted one period before each wait period and released during the last one.
- R12: Low `chip_en` ends any burst within one system clock (WAIT inactive, `dout` zero). Requests made while it is low are ignored.
- R13: A request that arrives while a burst is in progress has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the burst clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable, active high; low aborts a burst |
| req | input | 1 | One-cycle burst request |
| start_addr | input | ADDR_W | Burst start address, sampled with `req` |
| bclk | input | 1 | Burst clock, oversampled internally |
| cfg_wait_pol | input | 1 | WAIT asserted level |
| cfg_hold2 | input | 1 | Two-period data hold |
| cfg_wait_early | input | 1 | WAIT leads by one period |
| cfg_seq | input | 1 | 1 sequential order, 0 interleaved order |
| cfg_rise | input | 1 | 1 rising active edge, 0 falling active edge |
| cfg_len8 | input | 1 | 1 eight-word burst, 0 four-word burst |
| cfg_lat | input | 3 | Initial latency in active edges |
| wait_pin | output | 1 | WAIT output |
| dout | output | DATA_W | Burst data, zero when not valid |

## Verification
The bench pursues several corner cases:
- A burst whose start address sits at the top of an aligned group. A design that failed to wrap inside the group would carry into the next group and read the wrong words.
- The output state right after the inactive burst-clock transition. A design that decoded the edge select wrongly would advance twice per period.
- Two-period hold combined with early WAIT. Here an off-by-one in the lead logic would leave WAIT asserted during valid data or released during the gap.
- Latency codes below the minimum, a second request mid-burst, and chip enable dropped during data. These catch designs that start data too soon, restart the burst, or leave WAIT asserted after an abort.

// File: rtl/brs_pkg.sv
package brs_pkg;

    localparam int LAT_W     = 3;
    localparam int IDX_W     = 3;
    localparam int LEN_SHORT = 4;
    localparam int LEN_LONG  = 8;
    localparam int LAT_MIN   = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LAT  = 2'd1,
        ST_DATA = 2'd2
    } st_e;

    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_GAP    = 2'd2
    } ph_e;

    typedef struct packed {
        logic             hold2;
        logic             early;
        logic             seq;
        logic             len8;
        logic [LAT_W-1:0] lat;
    } cfg_t;

    function automatic logic [LAT_W-1:0] clamp_lat(input logic [LAT_W-1:0] raw);
        return (raw < LAT_W'(LAT_MIN)) ? LAT_W'(LAT_MIN) : raw;
    endfunction

endpackage

// File: rtl/brs_edge.sv
module brs_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic rise_sel,
    output logic act
);

    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] sync_d;
    logic              hist_q;
    logic              level;
    logic              rise;
    logic              fall;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = bclk;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], bclk};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            hist_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        level = sync_q[STAGES-1];
        rise  = level & ~hist_q;
        fall  = ~level & hist_q;
        act   = rise_sel ? rise : fall;
    end

endmodule

// File: rtl/brs_addr.sv
module brs_addr
    import brs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] start,
    input  logic [IDX_W-1:0]  idx,
    input  logic              len8,
    input  logic              seq,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] MASK_S = ADDR_W'(LEN_SHORT - 1);
    localparam logic [ADDR_W-1:0] MASK_L = ADDR_W'(LEN_LONG - 1);

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] moved;

    always_comb begin
        mask  = len8 ? MASK_L : MASK_S;
        step  = ADDR_W'(idx);
        moved = seq ? (start + step) : (start ^ step);
        addr  = (start & ~mask) | (moved & mask);
    end

endmodule

// File: rtl/brs_store.sv
module brs_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell
            localparam logic [7:0] A8 = 8'(g);
            assign cells[g] = DATA_W'({~A8, A8});
        end
    endgenerate

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/brs_ctl.sv
module brs_ctl
    import brs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              req,
    input  logic              act,
    input  cfg_t              cfg_in,
    input  logic [ADDR_W-1:0] start_in,
    output logic              busy,
    output logic              valid,
    output logic              wait_now,
    output logic              wait_next,
    output logic              cur_early,
    output logic              cur_len8,
    output logic              cur_seq,
    output logic [ADDR_W-1:0] cur_start,
    output logic [IDX_W-1:0]  cur_idx
);

    typedef struct packed {
        st_e               st;
        cfg_t              cfg;
        logic [ADDR_W-1:0] start;
        logic [LAT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        ph_e               ph;
    } ctl_t;

    ctl_t            r_q;
    ctl_t            r_d;
    logic            last_d;
    logic [LAT_W:0]  cnt_inc;
    logic [LAT_W:0]  lat_ext;

    always_comb begin
        r_d     = r_q;
        last_d  = (r_q.idx == (r_q.cfg.len8 ? IDX_W'(LEN_LONG - 1) : IDX_W'(LEN_SHORT - 1)));
        cnt_inc = {1'b0, r_q.cnt} + (LAT_W+1)'(1);
        lat_ext = {1'b0, r_q.cfg.lat};

        unique case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.st      = ST_LAT;
                    r_d.cfg     = cfg_in;
                    r_d.cfg.lat = clamp_lat(cfg_in.lat);
                    r_d.start   = start_in;
                    r_d.cnt     = '0;
                    r_d.idx     = '0;
                    r_d.ph      = PH_FIRST;
                end
            end
            ST_LAT: begin
                if (act) begin
                    if (cnt_inc == lat_ext) begin
                        r_d.st  = ST_DATA;
                        r_d.idx = '0;
                        r_d.ph  = PH_FIRST;
                    end else begin
                        r_d.cnt = cnt_inc[LAT_W-1:0];
                    end
                end
            end
            ST_DATA: begin
                if (act) begin
                    unique case (r_q.ph)
                        PH_FIRST: begin
                            if (r_q.cfg.hold2) begin
                                r_d.ph = PH_SECOND;
                            end else if (last_d) begin
                                r_d.st = ST_IDLE;
                            end else begin
                                r_d.idx = r_q.idx + IDX_W'(1);
                            end
                        end
                        PH_SECOND: begin
                            if (last_d) begin
                                r_d.st = ST_IDLE;
                            end else begin
                                r_d.ph = PH_GAP;
                            end
                        end
                        default: begin
                            r_d.ph  = PH_FIRST;
                            r_d.idx = r_q.idx + IDX_W'(1);
                        end
                    endcase
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (!chip_en) begin
            r_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy      = (r_q.st != ST_IDLE);
        valid     = (r_q.st == ST_DATA) && (r_q.ph != PH_GAP);
        wait_now  = (r_q.st == ST_LAT) || ((r_q.st == ST_DATA) && (r_q.ph == PH_GAP));
        wait_next = ((r_q.st == ST_LAT) && (cnt_inc < lat_ext))
                 || ((r_q.st == ST_DATA) && (r_q.ph == PH_SECOND) && !last_d);
        cur_early = r_q.cfg.early;
        cur_len8  = r_q.cfg.len8;
        cur_seq   = r_q.cfg.seq;
        cur_start = r_q.start;
        cur_idx   = r_q.idx;
    end

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
    import brs_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              bclk,
    input  logic              cfg_wait_pol,
    input  logic              cfg_hold2,
    input  logic              cfg_wait_early,
    input  logic              cfg_seq,
    input  logic              cfg_rise,
    input  logic              cfg_len8,
    input  logic [2:0]        cfg_lat,
    output logic              wait_pin,
    output logic [DATA_W-1:0] dout
);

    cfg_t              cfg_in;
    logic              act;
    logic              busy;
    logic              valid;
    logic              wait_now;
    logic              wait_next;
    logic              cur_early;
    logic              cur_len8;
    logic              cur_seq;
    logic [ADDR_W-1:0] cur_start;
    logic [IDX_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wait_on;

    always_comb begin
        cfg_in.hold2 = cfg_hold2;
        cfg_in.early = cfg_wait_early;
        cfg_in.seq   = cfg_seq;
        cfg_in.len8  = cfg_len8;
        cfg_in.lat   = LAT_W'(cfg_lat);
    end

    brs_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .rise_sel (cfg_rise),
        .act      (act)
    );

    brs_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_en   (chip_en),
        .req       (req),
        .act       (act),
        .cfg_in    (cfg_in),
        .start_in  (start_addr),
        .busy      (busy),
        .valid     (valid),
        .wait_now  (wait_now),
        .wait_next (wait_next),
        .cur_early (cur_early),
        .cur_len8  (cur_len8),
        .cur_seq   (cur_seq),
        .cur_start (cur_start),
        .cur_idx   (cur_idx)
    );

    brs_addr #(.ADDR_W(ADDR_W)) u_addr (
        .start (cur_start),
        .idx   (cur_idx),
        .len8  (cur_len8),
        .seq   (cur_seq),
        .addr  (rd_addr)
    );

    brs_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_comb begin
        wait_on  = cur_early ? wait_next : wait_now;
        wait_pin = wait_on ? cfg_wait_pol : ~cfg_wait_pol;
        dout     = valid ? rd_data : '0;
    end

endmodule

// File: rtl/brs_chk.sv
module brs_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en,
    input logic              req,
    input logic              cfg_wait_pol,
    input logic              cfg_wait_early,
    input logic              act,
    input logic              busy,
    input logic              wait_pin,
    input logic [DATA_W-1:0] dout
);

    AST_IDLE_WAIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (wait_pin != cfg_wait_pol)); // R1

    AST_INVALID_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wait_early && wait_pin == cfg_wait_pol) |-> (dout == '0)); // R3

    AST_READY_DATA_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_wait_early && wait_pin != cfg_wait_pol) |-> (dout != '0)); // R3

    AST_NO_EDGE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && !act && !req) |=> $stable(dout)); // R5

    AST_CE_DROP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> (wait_pin != cfg_wait_pol)); // R12

    AST_CE_DROP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> (dout == '0)); // R12

endmodule

bind burst_rd_seq brs_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .chip_en        (chip_en),
    .req            (req),
    .cfg_wait_pol   (cfg_wait_pol),
    .cfg_wait_early (cfg_wait_early),
    .act            (act),
    .busy           (busy),
    .wait_pin       (wait_pin),
    .dout           (dout)
);

// File: tb/sim_burst_rd_seq.sv
module sim_burst_rd_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_en = 1'b1;
    logic        req = 1'b0;
    logic [5:0]  start_addr = '0;
    logic        bclk = 1'b0;
    logic        cfg_wait_pol = 1'b0;
    logic        cfg_hold2 = 1'b0;
    logic        cfg_wait_early = 1'b0;
    logic        cfg_seq = 1'b1;
    logic        cfg_rise = 1'b1;
    logic        cfg_len8 = 1'b0;
    logic [2:0]  cfg_lat = 3'd2;
    logic        wait_pin;
    logic [15:0] dout;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int m_lat, m_end, m_len, m_start;
    bit m_hold, m_early, m_pol, m_seq;

    always #10 clk = ~clk;

    burst_rd_seq u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .chip_en        (chip_en),
        .req            (req),
        .start_addr     (start_addr),
        .bclk           (bclk),
        .cfg_wait_pol   (cfg_wait_pol),
        .cfg_hold2      (cfg_hold2),
        .cfg_wait_early (cfg_wait_early),
        .cfg_seq        (cfg_seq),
        .cfg_rise       (cfg_rise),
        .cfg_len8       (cfg_len8),
        .cfg_lat        (cfg_lat),
        .wait_pin       (wait_pin),
        .dout           (dout)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic bit w_at(input int s);
        if (s < m_lat) return 1'b1;
        if (s >= m_end) return 1'b0;
        return m_hold && (((s - m_lat) % 3) == 2);
    endfunction

    function automatic int exp_pin(input int s);
        bit a;
        a = m_early ? w_at(s + 1) : w_at(s);
        return a ? int'(m_pol) : int'(!m_pol);
    endfunction

    function automatic int exp_dout(input int s);
        int k, idx, mask, a;
        if (s < m_lat || s >= m_end) return 0;
        k = s - m_lat;
        if (m_hold) begin
            if ((k % 3) == 2) return 0;
            idx = k / 3;
        end else begin
            idx = k;
        end
        mask = m_len - 1;
        if (m_seq) a = (m_start & ~mask) | ((m_start + idx) & mask);
        else       a = m_start ^ idx;
        a = a & 63;
        return ((255 - a) << 8) | a;
    endfunction

    task automatic check_slot(input string tag, input int s);
        chk(tag, $sformatf("wait_pin slot %0d", s), int'(wait_pin), exp_pin(s));
        chk(tag, $sformatf("dout slot %0d", s), int'(dout), exp_dout(s));
    endtask

    // one burst-clock period: inactive transition, mid check, active transition, settle
    task automatic step(input string tag, input int prev);
        repeat (3) @(negedge clk);
        bclk = ~bclk;
        repeat (3) @(negedge clk);
        if (prev >= 0) begin
            chk({tag, " R5"}, "wait_pin after inactive edge", int'(wait_pin), exp_pin(prev));
            chk({tag, " R5"}, "dout after inactive edge", int'(dout), exp_dout(prev));
        end
        @(negedge clk);
        bclk = ~bclk;
        repeat (5) @(negedge clk);
    endtask

    task automatic setup(input bit pol, input bit hold2, input bit early, input bit seq,
                         input bit rise, input bit len8, input int lat, input int start);
        @(negedge clk);
        cfg_wait_pol   = pol;
        cfg_hold2      = hold2;
        cfg_wait_early = early;
        cfg_seq        = seq;
        cfg_rise       = rise;
        cfg_len8       = len8;
        cfg_lat        = lat[2:0];
        bclk           = rise;
        m_pol   = pol;
        m_hold  = hold2;
        m_early = early;
        m_seq   = seq;
        m_len   = len8 ? 8 : 4;
        m_lat   = (lat < 2) ? 2 : lat;
        m_start = start;
        m_end   = m_lat + (hold2 ? 3 * m_len - 1 : m_len);
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_req(input int start);
        start_addr = start[5:0];
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        start_addr = ~start[5:0];
    endtask

    task automatic run_burst(input string tag, input bit pol, input bit hold2, input bit early,
                             input bit seq, input bit rise, input bit len8, input int lat,
                             input int start, input bit poke);
        setup(pol, hold2, early, seq, rise, len8, lat, start);
        pulse_req(start);
        repeat (2) @(negedge clk);
        check_slot(tag, 0);
        for (int s = 1; s <= m_end + 1; s++) begin
            if (poke && s == 2) begin
                pulse_req(start + 17);
            end
            step(tag, s - 1);
            check_slot(tag, s);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic ce_abort();
        setup(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2, 8);
        pulse_req(8);
        repeat (2) @(negedge clk);
        check_slot("R12 pre", 0);
        for (int s = 1; s <= 3; s++) begin
            step("R12 pre", s - 1);
            check_slot("R12 pre", s);
        end
        chip_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12", "wait_pin after chip_en drop", int'(wait_pin), 1);
        chk("R12", "dout after chip_en drop", int'(dout), 0);
        pulse_req(8);
        for (int s = 0; s < 3; s++) begin
            step("R12", -1);
            chk("R12", "wait_pin with chip_en low", int'(wait_pin), 1);
            chk("R12", "dout with chip_en low", int'(dout), 0);
        end
        @(negedge clk);
        chip_en = 1'b1;
        repeat (4) @(negedge clk);
        run_burst("R12 recover", 0, 0, 0, 1, 1, 0, 2, 8, 0);
    endtask

    task automatic reset_check();
        repeat (4) @(negedge clk);
        chk("R1", "wait_pin in reset", int'(wait_pin), 1);
        chk("R1", "dout in reset", int'(dout), 0);
        cfg_wait_pol = 1'b1;
        @(negedge clk);
        chk("R1 R4", "inactive wait_pin high polarity", int'(wait_pin), 0);
        cfg_wait_pol = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "wait_pin idle after reset", int'(wait_pin), 1);
        chk("R1", "dout idle after reset", int'(dout), 0);
    endtask

    initial begin
        reset_check();
        run_burst("R2 R3 R6 R7 R8", 0, 0, 0, 1, 1, 0, 3, 6, 0);
        run_burst("R4 R5 R9", 1, 0, 0, 0, 0, 1, 2, 13, 0);
        run_burst("R10", 0, 1, 0, 1, 1, 0, 4, 'h21, 0);
        run_burst("R11 hold", 1, 1, 1, 0, 1, 0, 5, 'h2e, 0);
        run_burst("R11", 0, 0, 1, 1, 0, 1, 3, 'h3b, 0);
        run_burst("R6 R13", 0, 0, 0, 1, 1, 0, 0, 'h09, 1);
        run_burst("R7 R8 wrap", 1, 0, 0, 1, 1, 1, 7, 63, 0);
        run_burst("R6 R9 R10", 0, 1, 0, 0, 0, 0, 1, 5, 0);
        ce_abort();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule